// File: doc/BRIEF.md
# Track-to-Unit Connection Box with Realignment Delay

This block sits at one input of a computational unit inside a virtual routing fabric. Several routing tracks of equal width pass next to the unit. A configuration field picks one of them, and the block sends the picked value to the unit input.

The value first passes through a programmable number of plain pipeline registers. The place-and-route step knows how many hops each route takes. It sets the delay so that every route arriving at a unit has the same total pipeline depth. The tools can then treat the interconnect as if it had no registers.

The delay line always holds DMAX-1 registers. The delay field only chooses which tap drives the output. Changing the delay therefore leaves the values already in flight untouched.

Both configuration fields are shifted in one bit per cycle through a serial chain. The chain output lets several boxes be daisy-chained.

Top module: `cbox_realign`

## Requirements
- R1: With the track-select field equal to i, the unit input carries track i, which is bits [i*W +: W] of `trk_in`. The output is delayed by the configured amount.
- R2: With the delay field equal to 0, the selected track drives `cu_in` in the same cycle, with no register on the path.
- R3: With the delay field equal to k, where 1 <= k <= DMAX-1, a value on the selected track in cycle t appears on `cu_in` in cycle t+k.
- R4: A delay code greater than DMAX-1 behaves as DMAX-1. With the defaults, codes 6 and 7 both give a delay of 5.
- R5: The configuration word has the track-select field in its low SW bits and the delay field in the DW bits above it.
  - While `cfg_en` is high, the word shifts by one bit toward bit 0 on each clock and takes `cfg_bit` into its top bit.
  - Loading a word therefore takes SW+DW clocks, sending the word's bit 0 first.
  - `cfg_out` always shows bit 0 of the stored word. While a new word is loaded, the old word leaves the chain LSB first.
- R6: While `cfg_en` is low, the configuration word holds its value, whatever `cfg_bit` does.
- R7: A synchronous reset clears every realignment register to zero and leaves the configuration word unchanged.
  - With the delay field at k, `cu_in` is therefore zero in the first k cycles after reset.
  - In cycle k after reset, `cu_in` shows the value that was on the track in the first cycle after reset.
- R8: Changing the delay field does not flush the delay line. Right after a new delay k takes effect, `cu_in` shows the value the track carried k cycles earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_bit | input | 1 | Serial configuration data in |
| cfg_out | output | 1 | Serial configuration data out (bit 0 of stored word) |
| trk_in | input | NTRK*W | Adjacent routing tracks, track i at bits [i*W +: W] |
| cu_in | output | W | Value delivered to the computational unit input |

## Verification
The latency assertions assume that the configuration word does not change in the cycles the check looks back over. The one-stage assertion looks back one cycle, and it also relies on the delay line having been loaded from the currently selected track.

The stimulus keeps to this. After each new word is loaded, it holds `cfg_en` low for longer than the deepest delay before comparing the output. During that hold it toggles `cfg_bit` to show that the word stays put.

One test changes the delay without a settling gap. It drives the same value on every track, so that the intermediate track selections seen during shifting cannot affect the expected output.

// File: rtl/cbox_realign.sv
module cbox_realign #(
  parameter int W    = 8,
  parameter int NTRK = 4,
  parameter int DMAX = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en,
  input  logic              cfg_bit,
  output logic              cfg_out,
  input  logic [NTRK*W-1:0] trk_in,
  output logic [W-1:0]      cu_in
);
  localparam int SW  = (NTRK > 1) ? $clog2(NTRK) : 1;
  localparam int DW  = (DMAX > 1) ? $clog2(DMAX) : 1;
  localparam int CW  = SW + DW;
  localparam int NST = (DMAX > 1) ? DMAX - 1 : 1;

  logic [CW-1:0]    cfg_q;
  logic [SW-1:0]    sel_f;
  logic [DW-1:0]    dly_f;
  logic [DW-1:0]    dly_eff;
  logic [W-1:0]     pick;
  logic [W-1:0]     stage_q [NST];
  logic [W-1:0]     tap [DMAX];
  logic [NST*W-1:0] line_flat;

  always_ff @(posedge clk)
    if (cfg_en) cfg_q <= {cfg_bit, cfg_q[CW-1:1]};

  assign sel_f   = cfg_q[SW-1:0];
  assign dly_f   = cfg_q[CW-1:SW];
  assign cfg_out = cfg_q[0];
  assign dly_eff = (int'(dly_f) > DMAX - 1) ? DW'(DMAX - 1) : dly_f;

  always_comb begin
    pick = '0;
    for (int i = 0; i < NTRK; i++)
      if (int'(sel_f) == i) pick = trk_in[i*W +: W];
  end

  always_ff @(posedge clk)
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= pick;

  for (genvar k = 1; k < NST; k++) begin : g_stage
    always_ff @(posedge clk)
      if (rst) stage_q[k] <= '0;
      else     stage_q[k] <= stage_q[k-1];
  end

  assign tap[0] = pick;
  for (genvar k = 1; k < DMAX; k++) begin : g_tap
    assign tap[k] = stage_q[k-1];
  end

  for (genvar k = 0; k < NST; k++) begin : g_flat
    assign line_flat[k*W +: W] = stage_q[k];
  end

  assign cu_in = tap[dly_eff];
endmodule

// File: rtl/cbox_realign_chk.sv
module cbox_realign_chk #(
  parameter int W    = 8,
  parameter int NTRK = 4,
  parameter int DMAX = 6
) (
  input logic                                                   clk,
  input logic                                                   rst,
  input logic                                                   cfg_en,
  input logic                                                   cfg_bit,
  input logic [((NTRK>1)?$clog2(NTRK):1)+((DMAX>1)?$clog2(DMAX):1)-1:0] cfg_q,
  input logic [W-1:0]                                           pick,
  input logic [((DMAX>1)?DMAX-1:1)*W-1:0]                       line_flat,
  input logic [W-1:0]                                           cu_in
);
  localparam int SW  = (NTRK > 1) ? $clog2(NTRK) : 1;
  localparam int DW  = (DMAX > 1) ? $clog2(DMAX) : 1;
  localparam int CW  = SW + DW;
  localparam int NST = (DMAX > 1) ? DMAX - 1 : 1;

  logic [DW-1:0] dly;
  assign dly = cfg_q[CW-1:SW];

  AST_ZERO_DELAY_PASS: assert property (@(posedge clk) disable iff (rst)
    (dly == '0) |-> (cu_in == pick)); // R2

  AST_ONE_STAGE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (int'(dly) == 1 && !$past(rst)) |-> (cu_in == $past(pick))); // R3

  AST_FIRST_STAGE_LOAD: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (line_flat[W-1:0] == $past(pick))); // R3

  AST_CLAMP_LONGEST: assert property (@(posedge clk) disable iff (rst)
    (int'(dly) >= DMAX) |-> (cu_in == line_flat[NST*W-1 -: W])); // R4

  AST_CFG_SHIFT_IN: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> (cfg_q[CW-1] == $past(cfg_bit))); // R5

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> $stable(cfg_q)); // R6

  AST_RESET_CLEARS_LINE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (line_flat == '0)); // R7
endmodule

bind cbox_realign cbox_realign_chk #(.W(W), .NTRK(NTRK), .DMAX(DMAX)) u_chk (
  .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_bit(cfg_bit), .cfg_q(cfg_q),
  .pick(pick), .line_flat(line_flat), .cu_in(cu_in)
);

// File: tb/tb_cbox_realign.sv
module tb_cbox_realign;
  localparam int W = 8, NTRK = 4, DMAX = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_en = 1'b0;
  logic              cfg_bit = 1'b0;
  logic              cfg_out;
  logic [NTRK*W-1:0] trk_in;
  logic [W-1:0]      cu_in;

  int   gc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  logic same = 1'b0;
  logic [4:0] prev_word = '0;
  logic       prev_ok = 1'b0;

  // config word: {delay[2:0], track_sel[1:0]}
  localparam logic [4:0] VEC [8] = '{5'b000_00, 5'b001_01, 5'b010_10, 5'b011_11,
                                     5'b100_00, 5'b101_01, 5'b110_10, 5'b111_11};

  cbox_realign #(.W(W), .NTRK(NTRK), .DMAX(DMAX)) dut (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_bit(cfg_bit), .cfg_out(cfg_out),
    .trk_in(trk_in), .cu_in(cu_in)
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] tv(int c, int i);
    return 8'((c * 7 + i * 61 + 3) & 255);
  endfunction

  task automatic drive();
    for (int i = 0; i < NTRK; i++) trk_in[i*W +: W] = tv(gc, same ? 0 : i);
  endtask

  initial drive();
  always begin
    @(posedge clk);
    #2;
    gc = gc + 1;
    drive();
  end

  task automatic win();
    @(posedge clk);
    #3;
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, gc);
    end
  endtask

  task automatic load(logic [4:0] word);
    for (int j = 0; j < 5; j++) begin
      cfg_en  = 1'b1;
      cfg_bit = word[j];
      if (prev_ok) chk("R5 cfg_out", {7'd0, cfg_out}, {7'd0, prev_word[j]});
      win();
    end
    cfg_en    = 1'b0;
    prev_word = word;
    prev_ok   = 1'b1;
  endtask

  task automatic idle(int n);
    for (int j = 0; j < n; j++) begin
      cfg_bit = gc[0];
      win();
    end
    cfg_bit = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    win(); win(); win();
    rst = 1'b0;
    win();

    for (int v = 0; v < 8; v++) begin
      int sel, dly, eff;
      string lat;
      sel = int'(VEC[v][1:0]);
      dly = int'(VEC[v][4:2]);
      eff = (dly > DMAX - 1) ? DMAX - 1 : dly;
      lat = (dly == 0) ? "R2 passthrough" : (dly > DMAX - 1) ? "R4 clamp" : "R3 latency";
      load(VEC[v]);
      idle(DMAX + 1);
      chk("R1 track select", cu_in, tv(gc - eff, sel));
      win();
      chk(lat, cu_in, tv(gc - eff, sel));
      win();
      chk("R6 hold under cfg_bit toggling", cu_in, tv(gc - eff, sel));
      win();
    end

    // R7: reset clears delay line, config kept
    load(5'b101_10);
    idle(DMAX + 1);
    rst = 1'b1;
    win();
    rst = 1'b0;
    begin
      int r;
      r = gc;
      for (int m = 0; m < 5; m++) begin
        chk("R7 line cleared", cu_in, 8'h00);
        win();
      end
      chk("R7 first value after reset", cu_in, tv(r, 2));
      win();
      chk("R7 config kept", cu_in, tv(gc - 5, 2));
    end

    // R8: delay change keeps data in flight
    same = 1'b1;
    win();
    load(5'b001_00);
    idle(DMAX + 1);
    chk("R8 before change", cu_in, tv(gc - 1, 0));
    load(5'b100_11);
    chk("R8 after change", cu_in, tv(gc - 4, 0));
    win();
    chk("R8 after change next", cu_in, tv(gc - 4, 0));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule